// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flag Generation

This block is the arithmetic and logic stage of a small accumulator-based controller core. Each cycle it takes an operation code, two 8-bit operands and the current carry and auxiliary-carry bits from the status register. It forms an 8-bit result and new carry (C), auxiliary carry (AC), zero (Z) and overflow (OV) flag values, together with a four-bit mask that tells the status register which flags to load.

The arithmetic group covers addition and subtraction, each with and without the incoming carry, and a decimal adjust for packed BCD sums. The logic group covers increment, decrement, AND, OR, XOR and complement. The rotate group has plain left and right rotates and two rotates that pass through the carry bit. Subtraction follows the "carry means no borrow" convention throughout.

All outputs are captured in one output register stage. The result of an operation presented before a rising clock edge appears on the outputs just after that edge. Register file access, instruction decode and skip branches belong to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: While rst_n is low at a rising edge, every output is cleared to zero. Otherwise, at each rising edge the outputs take the values computed from the inputs present just before that edge, with exactly one cycle of latency.
- R2: Opcodes on op_i: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 DAA, 5 INC, 6 DEC, 7 AND, 8 OR, 9 XOR, 10 CPL, 11 RL, 12 RR, 13 RLC, 14 RRC. Code 15 gives result 0, every flag output 0 and update mask 0.
- R3: ADD gives (A+B) mod 256 and ADC gives (A+B+c_in) mod 256. C is the carry out of bit 7.
- R4: SUB gives A + ~B + 1 and SBC gives A + ~B + c_in, both mod 256. C is 1 when no borrow occurred, so for SUB C = (A >= B).
- R5: For the four add/subtract operations, AC is the carry out of bit 3 of the same sum A + B' + carry-in, where B' is B for additions and ~B for subtractions.
- R6: For the four add/subtract operations, OV is 1 exactly when the carry into bit 7 differs from the carry out of bit 7. This is the case when the signed result is out of range.
- R7: Z is 1 when the 8-bit result is zero, for every operation whose mask includes Z.
- R8: DAA works on A. It first adds 0x06 if A[3:0] > 9 or ac_in = 1. It then adds 0x60 if that first step carried out of bit 7, the upper nibble is now above 9, or c_in = 1. C is set when the 0x60 step is applied and equals c_in otherwise. Only C is updated.
- R9: INC gives A+1, DEC gives A-1, AND/OR/XOR combine A with B, and CPL gives ~A, all mod 256. Each updates only Z.
- R10: RL gives {A[6:0],A[7]} and RR gives {A[0],A[7:1]}. Both leave the update mask at zero.
- R11: RLC gives {A[6:0],c_in} with new C = A[7]. RRC gives {c_in,A[7:1]} with new C = A[0]. Both update only C.
- R12: Update mask bits are upd_o[0] C, upd_o[1] AC, upd_o[2] Z and upd_o[3] OV. The add/subtract operations set all four bits. A flag output whose mask bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (accumulator side) |
| b_i | input | 8 | Second operand |
| c_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary carry flag |
| result_o | output | 8 | Registered result |
| c_o | output | 1 | New carry value |
| ac_o | output | 1 | New auxiliary carry value |
| z_o | output | 1 | New zero value |
| ov_o | output | 1 | New overflow value |
| upd_o | output | 4 | Flag load mask {OV,Z,AC,C} |

## Verification
Two things can happen in the same operation. The first is that both decimal-adjust corrections apply in one cycle: the low-nibble correction pushes the upper nibble past nine or out of bit 7, which then forces the 0x60 step. The second is that a carry into bit 7 and a carry out of bit 7 arise together in one addition, which must leave OV at zero. The bench provokes both. It runs DAA over every A value with all four combinations of incoming C and AC, and it sweeps the add and subtract operations over all A values against a spread of B values that includes 0x7F, 0x80 and 0xFF, for both carry-in values. Each result is judged against an independent integer model: signed range for OV, nibble sums for AC, and a straight-line decimal correction for DAA.

// File: rtl/alu8_pkg.sv
// Package: shared opcode encoding, flag mask positions and widths for the
// eight-bit ALU. Assumes the opcode field is four bits wide.
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int FLAG_N = 4;

    // Positions of each flag inside the update mask
    localparam int UPD_C  = 0;
    localparam int UPD_AC = 1;
    localparam int UPD_Z  = 2;
    localparam int UPD_OV = 3;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_DAA = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_AND = 4'd7,
        OP_OR  = 4'd8,
        OP_XOR = 4'd9,
        OP_CPL = 4'd10,
        OP_RL  = 4'd11,
        OP_RR  = 4'd12,
        OP_RLC = 4'd13,
        OP_RRC = 4'd14,
        OP_NOP = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        GRP_ARITH = 2'd0,
        GRP_DAA   = 2'd1,
        GRP_BITS  = 2'd2,
        GRP_NONE  = 2'd3
    } alu_grp_e;

endpackage

// File: rtl/alu8_addsub.sv
// Module: segmented adder shared by add and subtract. It splits the sum
// into a low nibble, the middle bits and the top bit, so that the carry out
// of bit NIB_W-1 and the carry into and out of the top bit come out as
// plain wires. Assumes the caller has already inverted B for subtraction
// and has chosen the carry-in.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         c_o,
    output logic         ac_o,
    output logic         ov_o
);
    localparam int NW = W / 2;
    localparam int HW = W - NW - 1;

    logic [NW:0] lo_sum;
    logic [HW:0] mid_sum;
    logic [1:0]  top_sum;

    // Purpose: ripple the three segments and expose the segment carries
    always_comb begin
        lo_sum  = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]}
                + {{NW{1'b0}}, cin_i};
        mid_sum = {1'b0, a_i[W-2:NW]} + {1'b0, b_i[W-2:NW]}
                + {{HW{1'b0}}, lo_sum[NW]};
        top_sum = {1'b0, a_i[W-1]} + {1'b0, b_i[W-1]} + {1'b0, mid_sum[HW]};
    end

    // Purpose: assemble the sum and derive carry, half carry and overflow
    always_comb begin
        sum_o = {top_sum[0], mid_sum[HW-1:0], lo_sum[NW-1:0]};
        c_o   = top_sum[1];
        ac_o  = lo_sum[NW];
        ov_o  = top_sum[1] ^ mid_sum[HW];
    end

endmodule

// File: rtl/alu8_daa.sv
// Module: decimal adjust of an eight-bit packed BCD value in two steps.
// The low step adds six when the low digit is out of range or a half carry
// is pending. The high step adds 0x60 when the low step overflowed, the
// upper digit is out of range, or a carry is pending. Assumes the operand
// is the raw binary sum of two BCD bytes.
module alu8_daa
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic              c_in,
    input  logic              ac_in,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o
);
    localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
    localparam logic [DATA_W:0]  LO_ADJ    = (DATA_W+1)'(6);
    localparam logic [DATA_W-1:0] HI_ADJ   = DATA_W'(8'h60);

    logic              lo_fix;
    logic              hi_fix;
    logic [DATA_W:0]   stage1;

    // Purpose: low digit correction
    always_comb begin
        lo_fix = (a_i[NIB_W-1:0] > DIGIT_MAX) || ac_in;
        stage1 = {1'b0, a_i} + (lo_fix ? LO_ADJ : '0);
    end

    // Purpose: high digit correction and new carry
    always_comb begin
        hi_fix = stage1[DATA_W] || (stage1[DATA_W-1:NIB_W] > DIGIT_MAX) || c_in;
        res_o  = stage1[DATA_W-1:0] + (hi_fix ? HI_ADJ : '0);
        c_o    = hi_fix;
    end

endmodule

// File: rtl/alu8_bitops.sv
// Module: the logic group, increment and decrement, and the four rotates.
// The carry output is meaningful only for the rotates through carry.
// Assumes op_i was already decoded into this group by the caller; other
// codes give zero.
module alu8_bitops
    import alu8_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_in,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Purpose: pick the bitwise, counting or rotate result
    always_comb begin
        res_o = '0;
        c_o   = 1'b0;
        case (op_i)
            OP_INC: res_o = a_i + ONE;
            OP_DEC: res_o = a_i - ONE;
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_CPL: res_o = ~a_i;
            OP_RL:  res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
            OP_RR:  res_o = {a_i[0], a_i[DATA_W-1:1]};
            OP_RLC: begin
                res_o = {a_i[DATA_W-2:0], c_in};
                c_o   = a_i[DATA_W-1];
            end
            OP_RRC: begin
                res_o = {c_in, a_i[DATA_W-1:1]};
                c_o   = a_i[0];
            end
            default: begin
                res_o = '0;
                c_o   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
// Module: top of the eight-bit ALU. It decodes the opcode into a unit group,
// operand form and flag mask, selects the unit result, forms the flags and
// registers everything once. Assumes c_in and ac_in are the live status
// register bits and that the caller loads only the flags named in upd_o.
module alu8_core
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_in,
    input  logic              ac_in,
    output logic [DATA_W-1:0] result_o,
    output logic              c_o,
    output logic              ac_o,
    output logic              z_o,
    output logic              ov_o,
    output logic [FLAG_N-1:0] upd_o
);
    alu_op_e            op;
    alu_grp_e           grp;
    logic               inv_b;
    logic               carry_sel;
    logic [DATA_W-1:0]  b_eff;
    logic               cin_eff;
    logic [FLAG_N-1:0]  upd_n;

    logic [DATA_W-1:0]  as_sum;
    logic               as_c, as_ac, as_ov;
    logic [DATA_W-1:0]  daa_res;
    logic               daa_c;
    logic [DATA_W-1:0]  bit_res;
    logic               bit_c;

    logic [DATA_W-1:0]  res_n;
    logic               c_val;
    logic               c_n, ac_n, z_n, ov_n;

    assign op = alu_op_e'(op_i);

    // Purpose: decode group, operand inversion, carry source and flag mask
    always_comb begin
        grp       = GRP_NONE;
        inv_b     = 1'b0;
        carry_sel = 1'b0;
        upd_n     = '0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                grp       = GRP_ARITH;
                inv_b     = (op == OP_SUB) || (op == OP_SBC);
                carry_sel = (op == OP_ADC) || (op == OP_SBC);
                upd_n     = '1;
            end
            OP_DAA: begin
                grp          = GRP_DAA;
                upd_n[UPD_C] = 1'b1;
            end
            OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR, OP_CPL: begin
                grp          = GRP_BITS;
                upd_n[UPD_Z] = 1'b1;
            end
            OP_RL, OP_RR: begin
                grp = GRP_BITS;
            end
            OP_RLC, OP_RRC: begin
                grp          = GRP_BITS;
                upd_n[UPD_C] = 1'b1;
            end
            default: begin
                grp = GRP_NONE;
            end
        endcase
    end

    // Purpose: operand B and carry-in for the shared adder
    always_comb begin
        b_eff   = inv_b ? ~b_i : b_i;
        if (carry_sel)
            cin_eff = c_in;
        else
            cin_eff = inv_b;
    end

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_eff),
        .cin_i (cin_eff),
        .sum_o (as_sum),
        .c_o   (as_c),
        .ac_o  (as_ac),
        .ov_o  (as_ov)
    );

    alu8_daa u_daa (
        .a_i   (a_i),
        .c_in  (c_in),
        .ac_in (ac_in),
        .res_o (daa_res),
        .c_o   (daa_c)
    );

    alu8_bitops u_bitops (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .c_in  (c_in),
        .res_o (bit_res),
        .c_o   (bit_c)
    );

    // Purpose: select the unit result and its carry candidate
    always_comb begin
        case (grp)
            GRP_ARITH: begin res_n = as_sum;  c_val = as_c;  end
            GRP_DAA:   begin res_n = daa_res; c_val = daa_c; end
            GRP_BITS:  begin res_n = bit_res; c_val = bit_c; end
            default:   begin res_n = '0;      c_val = 1'b0;  end
        endcase
    end

    // Purpose: gate every flag with its mask bit
    always_comb begin
        c_n  = upd_n[UPD_C]  & c_val;
        ac_n = upd_n[UPD_AC] & as_ac;
        z_n  = upd_n[UPD_Z]  & (res_n == '0);
        ov_n = upd_n[UPD_OV] & as_ov;
    end

    // Purpose: single output register stage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            c_o      <= 1'b0;
            ac_o     <= 1'b0;
            z_o      <= 1'b0;
            ov_o     <= 1'b0;
            upd_o    <= '0;
        end else begin
            result_o <= res_n;
            c_o      <= c_n;
            ac_o     <= ac_n;
            z_o      <= z_n;
            ov_o     <= ov_n;
            upd_o    <= upd_n;
        end
    end

    // Subtract carry equals "A not below B"
    assert_sub_no_borrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SUB) |-> (c_n == (a_i >= b_i)));

    // Signed overflow of ADD seen from operand and result signs
    assert_add_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD) |-> (ov_n == ((a_i[DATA_W-1] == b_i[DATA_W-1]) &&
                                       (res_n[DATA_W-1] != a_i[DATA_W-1]))));

    // A pending carry is never cleared by the decimal adjust
    assert_daa_keeps_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_DAA) && c_in) |-> c_n);

    // Logic, count and complement touch only Z
    assert_logic_z_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i >= OP_INC) && (op_i <= OP_CPL)) |-> (upd_n == 4'b0100));

    // Plain rotates load no flag
    assert_rotate_no_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_RL) || (op_i == OP_RR)) |-> (upd_n == '0));

    // Rotate left through carry is a nine-bit rotate
    assert_rlc_nine_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RLC) |-> ({c_n, res_n} == {a_i, c_in}));

    // Registered outputs: a masked-off flag never reads 1
    assert_masked_flags_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_o & ~upd_o[UPD_C]) | (ac_o & ~upd_o[UPD_AC]) |
         (z_o & ~upd_o[UPD_Z]) | (ov_o & ~upd_o[UPD_OV])) == 1'b0);

endmodule

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;

    typedef struct packed {
        logic [7:0] res;
        logic       c;
        logic       ac;
        logic       z;
        logic       ov;
        logic [3:0] upd;
        logic [3:0] op;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] a_i = 8'd0;
    logic [7:0] b_i = 8'd0;
    logic       c_in = 1'b0;
    logic       ac_in = 1'b0;
    logic [7:0] result_o;
    logic       c_o, ac_o, z_o, ov_o;
    logic [3:0] upd_o;

    int   n_checks = 0;
    int   n_fail = 0;
    int   cycles = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .c_in(c_in), .ac_in(ac_in), .result_o(result_o), .c_o(c_o),
        .ac_o(ac_o), .z_o(z_o), .ov_o(ov_o), .upd_o(upd_o)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:             return "R3/R5/R6/R7/R12";
            4'd2, 4'd3:             return "R4/R5/R6/R7/R12";
            4'd4:                   return "R8";
            4'd5, 4'd6, 4'd7, 4'd8,
            4'd9, 4'd10:            return "R9/R7";
            4'd11, 4'd12:           return "R10";
            4'd13, 4'd14:           return "R11";
            default:                return "R2";
        endcase
    endfunction

    // Independent reference model written from the requirements
    function automatic exp_t model(input logic [3:0] op, input int a, input int b,
                                   input int c, input int ac);
        exp_t e;
        int   v, s, lo;
        e = '0;
        e.op = op;
        if (op <= 4'd3) begin
            int bb, cc, sa, sb, sg;
            bb = (op >= 4'd2) ? (255 - b) : b;
            cc = (op == 4'd0) ? 0 : (op == 4'd2) ? 1 : c;
            s  = a + bb + cc;
            lo = (a % 16) + (bb % 16) + cc;
            sa = (a > 127) ? a - 256 : a;
            sb = (bb > 127) ? bb - 256 : bb;
            sg = sa + sb + cc;
            e.res = 8'(s);
            e.c   = (s > 255);
            e.ac  = (lo > 15);
            e.ov  = (sg > 127) || (sg < -128);
            e.z   = ((s % 256) == 0);
            e.upd = 4'b1111;
        end else if (op == 4'd4) begin
            v = a;
            if ((a % 16) > 9 || ac != 0) v = v + 6;
            if (v > 255 || ((v / 16) % 16) > 9 || c != 0) begin
                v = v + 96;
                e.c = 1'b1;
            end else begin
                e.c = 1'b0;
            end
            e.res = 8'(v);
            e.upd = 4'b0001;
        end else if (op <= 4'd10) begin
            case (op)
                4'd5:    v = (a + 1) % 256;
                4'd6:    v = (a + 255) % 256;
                4'd7:    v = a & b;
                4'd8:    v = a | b;
                4'd9:    v = a ^ b;
                default: v = 255 - a;
            endcase
            e.res = 8'(v);
            e.z   = (v == 0);
            e.upd = 4'b0100;
        end else if (op == 4'd11) begin
            e.res = 8'(((a * 2) % 256) + (a / 128));
        end else if (op == 4'd12) begin
            e.res = 8'((a / 2) + (a % 2) * 128);
        end else if (op == 4'd13) begin
            e.res = 8'(((a * 2) % 256) + c);
            e.c   = (a >= 128);
            e.upd = 4'b0001;
        end else if (op == 4'd14) begin
            e.res = 8'((a / 2) + c * 128);
            e.c   = (a % 2);
            e.upd = 4'b0001;
        end
        return e;
    endfunction

    // Driver: apply one operation away from the active edge and queue its expectation
    task automatic drive(input logic [3:0] op, input int a, input int b,
                         input int c, input int ac);
        @(negedge clk);
        op_i  = op;
        a_i   = 8'(a);
        b_i   = 8'(b);
        c_in  = (c != 0);
        ac_in = (ac != 0);
        exp_q.push_back(model(op, a, b, c, ac));
    endtask

    // Monitor: after each edge, compare the registered outputs with the oldest item
    always begin
        @(posedge clk);
        #1;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            logic [15:0] got, want;
            e = exp_q.pop_front();
            got  = {result_o, c_o, ac_o, z_o, ov_o, upd_o};
            want = {e.res, e.c, e.ac, e.z, e.ov, e.upd};
            n_checks++;
            if (got !== want) begin
                n_fail++;
                $display("FAIL %s op=%0d a=%02h b=%02h actual=%04h expected=%04h (R1 latency)",
                         req_of(e.op), e.op, a_i, b_i, got, want);
            end
        end
    end

    // Watchdog
    always begin
        @(posedge clk);
        cycles++;
        if (cycles > 190000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<190000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check_reset_zero;
        @(posedge clk);
        #1;
        n_checks++;
        if ({result_o, c_o, ac_o, z_o, ov_o, upd_o} !== 16'h0) begin
            n_fail++;
            $display("FAIL R1 reset: actual=%04h expected=0000",
                     {result_o, c_o, ac_o, z_o, ov_o, upd_o});
        end
    endtask

    initial begin
        int blist[20];
        for (int k = 0; k < 16; k++) blist[k] = k * 17;
        blist[16] = 8'h01; blist[17] = 8'h7F; blist[18] = 8'h80; blist[19] = 8'hFE;

        // R1: reset holds outputs at zero even with live inputs
        op_i = 4'd1; a_i = 8'hFF; b_i = 8'h01; c_in = 1'b1; ac_in = 1'b1;
        for (int k = 0; k < 3; k++) check_reset_zero();
        @(negedge clk);
        rst_n = 1'b1;

        // R3..R7, R9..R12: sweep A fully against a spread of B, both carry values
        for (int op = 0; op < 15; op++) begin
            if (op == 4) continue;
            for (int c = 0; c < 2; c++)
                for (int a = 0; a < 256; a++)
                    for (int k = 0; k < 20; k++)
                        drive(4'(op), a, blist[k], c, (a ^ k) & 1);
        end

        // R8: decimal adjust over every A and every incoming C and AC
        for (int c = 0; c < 2; c++)
            for (int ac = 0; ac < 2; ac++)
                for (int a = 0; a < 256; a++)
                    drive(4'd4, a, 0, c, ac);

        // R2: unused code gives all zeros
        drive(4'd15, 8'hFF, 8'hFF, 1, 1);
        drive(4'd15, 8'h00, 8'h00, 0, 0);

        // R1: a reset in mid-stream clears outputs again
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        rst_n = 1'b0;
        op_i = 4'd0; a_i = 8'h80; b_i = 8'h80;
        check_reset_zero();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule